// File: doc/BRIEF.md
# Mode-Controlled Bit-Slice Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit of configurable width. It is made from identical one-bit cells. A mode input chooses between a logical group and an arithmetic group of four operations each. A two-bit select code picks the operation within the group, and a carry input adds one more in arithmetic mode. That gives twelve distinct operations on operands `opa` and `opb`, which produce result `res` and carry-out `cout`.

Every cell uses one full adder for both groups. Bit 0 of the select code inverts the A bit before the adder. Bit 1 of the select code lets the B bit through; when it is 0 the adder sees 0 for B. In logical mode the carry entering the cell is forced to zero, so the sum output turns into a plain XOR of the gated A and B terms. Carries ripple from bit 0 up to the top bit. The final carry is reported only in arithmetic mode.

Top module: `slice_alu`

## Requirements
- R1: With mode=0 and sel=2'b00, res equals opa.
- R2: With mode=0 and sel=2'b01, res equals the bitwise complement of opa.
- R3: With mode=0 and sel=2'b10, res equals opa XOR opb.
- R4: With mode=0 and sel=2'b11, res equals opa XNOR opb.
- R5: With mode=0, cout is 0 and cin has no effect on res.
- R6: With mode=1, cin=0 and sel[1]=0, {cout,res} equals opa (sel=2'b00) or NOT opa (sel=2'b01), zero-extended; cout is 0.
- R7: With mode=1, cin=0 and sel=2'b10, {cout,res} equals opa+opb at width+1 bits.
- R8: With mode=1, cin=0 and sel=2'b11, {cout,res} equals (NOT opa)+opb at width+1 bits.
- R9: With mode=1, cin=1 and sel[1]=0, {cout,res} equals opa+1 (sel=2'b00) or (NOT opa)+1 (sel=2'b01), so NOT 0 + 1 gives res=0 and cout=1.
- R10: With mode=1, cin=1 and sel=2'b10, {cout,res} equals opa+opb+1.
- R11: With mode=1, cin=1 and sel=2'b11, res equals opb minus opa modulo 2^width, and cout is 1 exactly when opb >= opa.
- R12: All of R1 to R11 hold for every legal WIDTH, because the cell chain is generated from the parameter.

Select encoding: sel[0] inverts opa; sel[1] lets opb into the adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 1 | 0 = logical group, 1 = arithmetic group |
| sel | input | 2 | Operation select: bit 0 inverts A, bit 1 lets B in |
| cin | input | 1 | Carry into bit 0, used only when mode=1 |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| res | output | WIDTH | Result |
| cout | output | 1 | Carry out of the top cell when mode=1, else 0 |

## Verification
The bench builds two copies of the block, one at the default width of 4 and one at width 8, and drives both with the same controls. At width 4 the stimulus covers every combination of mode, select, carry-in and both operands. That includes subtracting equal operands, full wrap-around on increment, and every carry pattern through the four-cell chain. The 8-bit copy gets pseudo-random operands plus directed corners such as all-ones plus one and B minus A with A greater than B. This shows that the generated chain and the carry-out position follow the width parameter.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  // Gated operands presented to one cell's full adder.
  typedef struct packed {
    logic xa;   // A bit, possibly inverted
    logic yb;   // B bit, or 0 when blocked
    logic zc;   // incoming carry, or 0 in logical mode
  } cell_terms_t;

  // Position of each control within the select code.
  localparam int unsigned SEL_INV_A = 0;
  localparam int unsigned SEL_USE_B = 1;

  function automatic cell_terms_t gate_terms(input logic a_bit, input logic b_bit,
                                             input logic c_bit, input logic mode,
                                             input logic [1:0] sel);
    cell_terms_t t;
    t.xa = a_bit ^ sel[SEL_INV_A];
    t.yb = b_bit & sel[SEL_USE_B];
    t.zc = c_bit & mode;
    return t;
  endfunction

  function automatic logic fa_sum(input cell_terms_t t);
    return t.xa ^ t.yb ^ t.zc;
  endfunction

  function automatic logic fa_carry(input cell_terms_t t);
    return (t.xa & t.yb) | (t.zc & (t.xa ^ t.yb));
  endfunction

endpackage

// File: rtl/slice_alu_cell.sv
module slice_alu_cell
  import slice_alu_pkg::*;
(
  input  logic       mode,
  input  logic [1:0] sel,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       c_in,
  output logic       f_bit,
  output logic       c_out
);

  cell_terms_t terms;

  always_comb begin
    terms = gate_terms(a_bit, b_bit, c_in, mode, sel);
    f_bit = fa_sum(terms);
    c_out = fa_carry(terms);
  end

endmodule

// File: rtl/slice_alu_chain.sv
module slice_alu_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             mode,
  input  logic [1:0]       sel,
  input  logic             cin,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic [WIDTH:0]   carry
);

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    slice_alu_cell u_cell (
      .mode  (mode),
      .sel   (sel),
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .c_in  (carry[i]),
      .f_bit (res[i]),
      .c_out (carry[i+1])
    );
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             mode,
  input  logic [1:0]       sel,
  input  logic             cin,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic             cout
);

  localparam int unsigned CW = WIDTH + 1;

  // Ripple carries, exposed as a named wire for inspection.
  logic [CW-1:0] carry_chain;

  slice_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .mode  (mode),
    .sel   (sel),
    .cin   (cin),
    .opa   (opa),
    .opb   (opb),
    .res   (res),
    .carry (carry_chain)
  );

  // Top carry counts only in arithmetic mode.
  assign cout = mode & carry_chain[CW-1];

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int unsigned W = 4
) (
  input logic         mode,
  input logic [1:0]   sel,
  input logic         cin,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] res,
  input logic         cout
);

  logic [W:0] arith_ref;

  always_comb begin
    arith_ref = {1'b0, (sel[0] ? ~opa : opa)}
              + {1'b0, (sel[1] ? opb : {W{1'b0}})}
              + {{W{1'b0}}, cin};
  end

  always_comb begin
    if (!mode && sel == 2'b00) begin
      AST_LOGIC_PASS: assert (res == opa) else $error("pass"); // R1
    end
    if (!mode && sel == 2'b01) begin
      AST_LOGIC_INVERT: assert (res == ~opa) else $error("invert"); // R2
    end
    if (!mode && sel == 2'b10) begin
      AST_LOGIC_XOR: assert (res == (opa ^ opb)) else $error("xor"); // R3
    end
    if (!mode && sel == 2'b11) begin
      AST_LOGIC_XNOR: assert (res == ~(opa ^ opb)) else $error("xnor"); // R4
    end
    if (!mode) begin
      AST_LOGIC_NO_CARRY: assert (cout == 1'b0) else $error("cout in logic mode"); // R5
    end
    if (mode && !cin && !sel[1]) begin
      AST_ARITH_A_ONLY: assert ({cout, res} == arith_ref && !cout) else $error("a only"); // R6
    end
    if (mode && !cin && sel == 2'b10) begin
      AST_ARITH_ADD: assert ({cout, res} == arith_ref) else $error("add"); // R7
    end
    if (mode && !cin && sel == 2'b11) begin
      AST_ARITH_NOTA_ADD: assert ({cout, res} == arith_ref) else $error("nota add"); // R8
    end
    if (mode && cin && !sel[1]) begin
      AST_ARITH_INCR: assert ({cout, res} == arith_ref) else $error("incr"); // R9
    end
    if (mode && cin && sel == 2'b10) begin
      AST_ARITH_ADD_INC: assert ({cout, res} == arith_ref) else $error("add inc"); // R10
    end
    if (mode && cin && sel == 2'b11) begin
      AST_ARITH_SUB: assert (res == opb - opa && cout == (opb >= opa)) else $error("sub"); // R11
    end
  end

endmodule

bind slice_alu slice_alu_chk #(.W(WIDTH)) u_chk (
  .mode (mode),
  .sel  (sel),
  .cin  (cin),
  .opa  (opa),
  .opb  (opb),
  .res  (res),
  .cout (cout)
);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       mode;
  logic [1:0] sel;
  logic       cin;
  logic [3:0] a4, b4, r4;
  logic [7:0] a8, b8, r8;
  logic       c4, c8;

  slice_alu #(.WIDTH(4)) u_dut (
    .mode(mode), .sel(sel), .cin(cin), .opa(a4), .opb(b4), .res(r4), .cout(c4));

  slice_alu #(.WIDTH(8)) u_dut_w8 (
    .mode(mode), .sel(sel), .cin(cin), .opa(a8), .opb(b8), .res(r8), .cout(c8));

  typedef struct {
    logic       m;
    string      tag;
    int         exp4;
    int         exp8;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Independent model: packs carry at bit 8 above the masked result.
  function automatic int model(int w, logic m, logic [1:0] s, logic c, int a, int b);
    int mask = (1 << w) - 1;
    int r;
    if (!m) begin
      case (s)
        2'b00: r = a;
        2'b01: r = ~a & mask;
        2'b10: r = a ^ b;
        default: r = ~(a ^ b) & mask;
      endcase
      return r;
    end
    if (s == 2'b11 && c) begin
      r = (b - a) & mask;                 // subtract form
      return r | ((b >= a) ? 256 : 0);
    end
    r = (s[0] ? (~a & mask) : a) + (s[1] ? b : 0) + int'(c);
    return (r & mask) | (((r >> w) & 1) << 8);
  endfunction

  function automatic string tag_of(logic m, logic [1:0] s, logic c);
    if (!m) case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
    if (!c) begin
      if (!s[1]) return "R6";
      return (s == 2'b10) ? "R7" : "R8";
    end
    if (!s[1]) return "R9";
    return (s == 2'b10) ? "R10" : "R11";
  endfunction

  task automatic drive(logic m, logic [1:0] s, logic c, logic [3:0] x4, logic [3:0] y4,
                       logic [7:0] x8, logic [7:0] y8);
    item_t it;
    @(posedge clk);
    mode = m; sel = s; cin = c; a4 = x4; b4 = y4; a8 = x8; b8 = y8;
    it.m = m;
    it.tag = tag_of(m, s, c);
    it.exp4 = model(4, m, s, c, int'(x4), int'(y4));
    it.exp8 = model(8, m, s, c, int'(x8), int'(y8));
    sb_q.push_back(it);
  endtask

  // Monitor: compares half a period after the inputs change.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        int got4, got8;
        it = sb_q.pop_front();
        got4 = (int'(c4) << 8) | int'(r4);
        got8 = (int'(c8) << 8) | int'(r8);
        total++;
        if (got4 != it.exp4) begin
          bad++;
          $display("FAIL %s w4: got %h expected %h", it.tag, got4, it.exp4);
        end
        total++;
        if (got8 != it.exp8) begin
          bad++;
          $display("FAIL R12 (%s) w8: got %h expected %h", it.tag, got8, it.exp8);
        end
        if (!it.m) begin
          total++;
          if (c4 !== 1'b0 || c8 !== 1'b0) begin   // R5
            bad++;
            $display("FAIL R5: cout got %b/%b expected 0/0", c4, c8);
          end
        end
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    mode = 0; sel = 0; cin = 0; a4 = 0; b4 = 0; a8 = 0; b8 = 0;
    // Zero inputs first: res=0, cout=0 (R1).
    drive(1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 8'h00, 8'h00);
    // Exhaustive at width 4; R5 covered by both cin values in logic mode.
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              lfsr = step(lfsr);
              drive(m[0], s[1:0], c[0], a[3:0], b[3:0], lfsr[7:0], lfsr[15:8]);
            end
    // Directed 8-bit corners (R12): wrap, equal subtract, A greater than B.
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++) begin
        drive(1'b1, s[1:0], c[0], 4'hF, 4'h1, 8'hFF, 8'h01);
        drive(1'b1, s[1:0], c[0], 4'h0, 4'hF, 8'h00, 8'hFF);
        drive(1'b1, s[1:0], c[0], 4'h7, 4'h7, 8'h5A, 8'h5A);
        drive(1'b1, s[1:0], c[0], 4'h9, 4'h3, 8'hC3, 8'h21);
        drive(1'b0, s[1:0], c[0], 4'hA, 4'h6, 8'hF0, 8'h3C);
      end
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule